// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level page table that sits in ordinary memory. A requester hands over one translation at a time: the linear address, a write flag and a user-mode flag. The block replies with a single-cycle pulse. On success it returns the physical address. On failure it returns a page fault with an exact 3-bit error code, and it also records the faulting address.

The walk reads the first-level (directory) entry, then the second-level (table) entry, over a plain 32-bit request/acknowledge memory port. When an accessed or dirty bit has to change, the block writes the entry back to memory. The block holds three values:

- a directory base register, loaded from bits 31:12 of the written word;
- a paging-enable bit; when it is clear, translation is the identity map and memory is not touched;
- the fault-address register.

A mode pin selects between two user-permission rules:

- relaxed: a user access is denied only if both levels deny it;
- strict: a user access is denied if either level denies it.

Requests use valid/ready. `req_ready` is high only while the walker is idle, so a requester holding `req_valid` simply waits through a walk in progress. The result side has no back-pressure: `rsp_done` or `rsp_fault` pulses for exactly one cycle, and `rsp_phys`/`rsp_err` hold their values until the next result. On the memory port, a transfer completes in a cycle where `mem_req` and `mem_ack` are both high. Until then, the walker holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `busy`=0, `rsp_done`=0, `rsp_fault`=0, `mem_req`=0, `fault_addr`=0, and paging is disabled.
- R2: With paging disabled, a request completes with `rsp_done` and `rsp_phys` equal to the linear address, and makes no memory access.
- R3: The directory entry is read at (base page << 12) + lin[31:22]*4, where the base page is bits 31:12 of the word written with `cfg_base_we`. The table entry is read at (directory entry bits 31:12 << 12) + lin[21:12]*4. On success, `rsp_phys` = {table entry bits 31:12, lin[11:0]}. While a memory access is waiting for `mem_ack`, its address and direction stay stable.
- R4: If an entry has its present bit (bit 0) clear, the walk ends in a fault. The error code then has bit 0 = 0, bit 1 = write flag and bit 2 = user flag.
- R5: For a user access, the user bit is bit 2 of each entry. With `strict_user`=0, the access is denied only when the user bit is clear at both levels. With `strict_user`=1, it is denied when the bit is clear at either level.
- R6: A user write is denied when the read/write bit (bit 1) is clear at either level. A user read ignores that bit. Supervisor accesses skip both the user check and the write check.
- R7: A permission denial reports error code 5 for a read and 7 for a write.
- R8: A present directory entry whose accessed bit (bit 5) is clear is written back with that bit set, before the table entry is read. This happens even if the table level then faults. If the bit is already set, there is no write.
- R9: A present, permitted table entry is written back with accessed set (and, for a write, dirty = bit 6 set) only when one of those bits changes. Otherwise there is no write, and there is never a write after a fault at the table level.
- R10: On every fault, `fault_addr` takes the linear address, in the same cycle as the `rsp_fault` pulse. It holds its value through later successful requests.
- R11: Each accepted request yields exactly one single-cycle pulse on `rsp_done` or `rsp_fault`. `busy`=1 and `req_ready`=0 from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Load the directory base register |
| cfg_base_wdata | input | 32 | Value to load; bits 31:12 become the base page |
| cfg_en_we | input | 1 | Load the paging-enable bit |
| cfg_en_wdata | input | 1 | New paging-enable value |
| strict_user | input | 1 | 0: deny user access only if both levels deny; 1: if either denies |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is at user level |
| rsp_done | output | 1 | One-cycle pulse: translation succeeded |
| rsp_fault | output | 1 | One-cycle pulse: page fault |
| rsp_phys | output | 32 | Physical address of the last success |
| rsp_err | output | 3 | Error code of the last fault |
| fault_addr | output | 32 | Linear address of the last fault |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A corrupted walk state shows up at the ports within the same request. Typical symptoms are:

- a memory access at the wrong address, or a write where none is due;
- a changed entry in memory that does not match the expected accessed/dirty bits;
- a wrong physical address or error code on the result pulse;
- a missing or doubled pulse.

Latched request fields that go wrong appear as a bad `rsp_phys` or `fault_addr` at the pulse ending that walk. A wrong base or enable register shows up on the very next request, as extra or missing memory traffic, or as a translation that points at the wrong table.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag positions
  localparam int PTE_P  = 0;
  localparam int PTE_RW = 1;
  localparam int PTE_US = 2;
  localparam int PTE_A  = 5;
  localparam int PTE_D  = 6;

  localparam logic [2:0] ERR_PROT = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB,
    ST_RESP
  } walk_st_t;
endpackage

// File: rtl/ptw_regs.sv
module ptw_regs #(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [AW-1:0]    base_wdata,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic             fa_load,
  input  logic [AW-1:0]    fa_value,
  output logic [AW-1:OFF_W] base_page,
  output logic             pg_en,
  output logic [AW-1:0]    fault_addr
);
  logic unused_low_bits;
  assign unused_low_bits = ^base_wdata[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_page  <= '0;
      pg_en      <= 1'b0;
      fault_addr <= '0;
    end else begin
      if (base_we) base_page  <= base_wdata[AW-1:OFF_W];
      if (en_we)   pg_en      <= en_wdata;
      if (fa_load) fault_addr <= fa_value;
    end
  end
endmodule

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pde,
  input  logic [AW-1:0] pte,
  input  logic          wr,
  input  logic          usr,
  input  logic          strict,
  output logic          deny,
  output logic          wb_need,
  output logic [AW-1:0] pte_new
);
  logic usr_lock_d, usr_lock_t, usr_deny, wr_deny;

  always_comb begin
    usr_lock_d = ~pde[PTE_US];
    usr_lock_t = ~pte[PTE_US];
    if (strict) usr_deny = usr_lock_d | usr_lock_t;
    else        usr_deny = usr_lock_d & usr_lock_t;
    wr_deny = wr & (~pde[PTE_RW] | ~pte[PTE_RW]);
    deny    = usr & (usr_deny | wr_deny);

    wb_need = ~pte[PTE_A] | (wr & ~pte[PTE_D]);
    pte_new = pte;
    pte_new[PTE_A] = 1'b1;
    if (wr) pte_new[PTE_D] = 1'b1;
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_lin,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              pg_en,
  input  logic [AW-1:OFF_W] base_page,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [AW-1:0]     mem_rdata,
  output logic [AW-1:0]     chk_pde,
  output logic [AW-1:0]     chk_pte,
  output logic              chk_wr,
  output logic              chk_usr,
  input  logic              chk_deny,
  input  logic              chk_wb,
  input  logic [AW-1:0]     chk_new,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [AW-1:0]     rsp_phys,
  output logic [2:0]        rsp_err,
  output logic              busy,
  output logic              fa_load,
  output logic [AW-1:0]     fa_value
);
  localparam int TOP_LO = OFF_W + IDX_W;

  walk_st_t        st;
  logic [AW-1:0]   lin_q, pde_q, pte_q, phys_q;
  logic            wr_q, usr_q, flt_q;
  logic [2:0]      err_q;
  logic [AW-1:0]   dir_addr, tbl_addr, pde_set_a;
  logic            dir_ack, tbl_ack, np_err_dir, np_err_tbl;

  assign dir_addr = {base_page, {OFF_W{1'b0}}}
                  + AW'({lin_q[AW-1:TOP_LO], 2'b00});
  assign tbl_addr = {pde_q[AW-1:OFF_W], {OFF_W{1'b0}}}
                  + AW'({lin_q[TOP_LO-1:OFF_W], 2'b00});

  always_comb begin
    pde_set_a = pde_q;
    pde_set_a[PTE_A] = 1'b1;
  end

  assign dir_ack    = (st == ST_DIR_RD) && mem_ack;
  assign tbl_ack    = (st == ST_TBL_RD) && mem_ack;
  assign np_err_dir = ~mem_rdata[PTE_P];
  assign np_err_tbl = ~mem_rdata[PTE_P];

  assign chk_pde = pde_q;
  assign chk_pte = (st == ST_TBL_RD) ? mem_rdata : pte_q;
  assign chk_wr  = wr_q;
  assign chk_usr = usr_q;

  assign fa_load  = (dir_ack && np_err_dir) || (tbl_ack && (np_err_tbl || chk_deny));
  assign fa_value = lin_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dir_addr;
    mem_wdata = '0;
    case (st)
      ST_DIR_RD: mem_req = 1'b1;
      ST_DIR_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pde_set_a;
      end
      ST_TBL_RD: begin
        mem_req  = 1'b1;
        mem_addr = tbl_addr;
      end
      ST_TBL_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tbl_addr;
        mem_wdata = chk_new;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      lin_q  <= '0;
      pde_q  <= '0;
      pte_q  <= '0;
      phys_q <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      flt_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          lin_q <= req_lin;
          wr_q  <= req_write;
          usr_q <= req_user;
          if (pg_en) st <= ST_DIR_RD;
          else begin
            phys_q <= req_lin;
            flt_q  <= 1'b0;
            st     <= ST_RESP;
          end
        end
        ST_DIR_RD: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (np_err_dir) begin
            flt_q <= 1'b1;
            err_q <= {usr_q, wr_q, 1'b0};
            st    <= ST_RESP;
          end else if (!mem_rdata[PTE_A]) st <= ST_DIR_WB;
          else st <= ST_TBL_RD;
        end
        ST_DIR_WB: if (mem_ack) st <= ST_TBL_RD;
        ST_TBL_RD: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (np_err_tbl) begin
            flt_q <= 1'b1;
            err_q <= {usr_q, wr_q, 1'b0};
            st    <= ST_RESP;
          end else if (chk_deny) begin
            flt_q <= 1'b1;
            err_q <= ERR_PROT | {1'b0, wr_q, 1'b0};
            st    <= ST_RESP;
          end else if (chk_wb) st <= ST_TBL_WB;
          else begin
            flt_q  <= 1'b0;
            phys_q <= {mem_rdata[AW-1:OFF_W], lin_q[OFF_W-1:0]};
            st     <= ST_RESP;
          end
        end
        ST_TBL_WB: if (mem_ack) begin
          flt_q  <= 1'b0;
          phys_q <= {pte_q[AW-1:OFF_W], lin_q[OFF_W-1:0]};
          st     <= ST_RESP;
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign rsp_done  = (st == ST_RESP) && !flt_q;
  assign rsp_fault = (st == ST_RESP) && flt_q;
  assign rsp_phys  = phys_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_base_we,
  input  logic [AW-1:0] cfg_base_wdata,
  input  logic          cfg_en_we,
  input  logic          cfg_en_wdata,
  input  logic          strict_user,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_lin,
  input  logic          req_write,
  input  logic          req_user,
  output logic          rsp_done,
  output logic          rsp_fault,
  output logic [AW-1:0] rsp_phys,
  output logic [2:0]    rsp_err,
  output logic [AW-1:0] fault_addr,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  logic [AW-1:OFF_W] base_page;
  logic              pg_en, fa_load, chk_wr, chk_usr, chk_deny, chk_wb;
  logic [AW-1:0]     fa_value, chk_pde, chk_pte, chk_new;

  ptw_regs #(.AW(AW), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .base_we(cfg_base_we), .base_wdata(cfg_base_wdata),
    .en_we(cfg_en_we), .en_wdata(cfg_en_wdata),
    .fa_load(fa_load), .fa_value(fa_value),
    .base_page(base_page), .pg_en(pg_en), .fault_addr(fault_addr)
  );

  ptw_check #(.AW(AW)) u_check (
    .pde(chk_pde), .pte(chk_pte), .wr(chk_wr), .usr(chk_usr),
    .strict(strict_user), .deny(chk_deny), .wb_need(chk_wb), .pte_new(chk_new)
  );

  ptw_seq #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user),
    .pg_en(pg_en), .base_page(base_page),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .chk_pde(chk_pde), .chk_pte(chk_pte), .chk_wr(chk_wr), .chk_usr(chk_usr),
    .chk_deny(chk_deny), .chk_wb(chk_wb), .chk_new(chk_new),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys),
    .rsp_err(rsp_err), .busy(busy), .fa_load(fa_load), .fa_value(fa_value)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pg_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_fault,
  input logic [2:0]    rsp_err,
  input logic [AW-1:0] fault_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata
);
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_fault) |=> !(rsp_done || rsp_fault)); // R11
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_fault)); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
  AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pg_en) |=> !mem_req); // R2
  AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0])); // R8
  AST_PROT_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && rsp_err[0]) |-> rsp_err[2]); // R7
  AST_FA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |=> ($stable(fault_addr) || rsp_fault)); // R10
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_en(pg_en),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
  .fault_addr(fault_addr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_base_we = 0, cfg_en_we = 0, cfg_en_wdata = 0, strict_user = 0;
  logic [31:0] cfg_base_wdata = '0;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_lin = '0;
  logic        req_ready, rsp_done, rsp_fault, busy, mem_req, mem_we;
  logic [31:0] rsp_phys, fault_addr, mem_addr, mem_wdata;
  logic [2:0]  rsp_err;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
    .cfg_en_we(cfg_en_we), .cfg_en_wdata(cfg_en_wdata), .strict_user(strict_user),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .rsp_done(rsp_done),
    .rsp_fault(rsp_fault), .rsp_phys(rsp_phys), .rsp_err(rsp_err),
    .fault_addr(fault_addr), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // memory model: 16 KiB, variable ack latency, backdoor loader
  logic [31:0] mem [0:4095];
  int n_wr = 0, n_acc = 0, bad_addr = 0, wait_cnt = 0, next_dly = 1;
  logic        bd_we = 0;
  logic [11:0] bd_idx = '0;
  logic [31:0] bd_val = '0;
  initial for (int i = 0; i < 4096; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (bd_we) mem[bd_idx] <= bd_val;
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[13:2]];
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          n_wr++;
        end
        n_acc++;
        if (mem_addr[31:14] != 0 || mem_addr[1:0] != 0) bad_addr++;
        wait_cnt = next_dly;
        next_dly = (next_dly + 1) % 3;
      end else wait_cnt = wait_cnt - 1;
    end
  end

  task automatic poke(input logic [11:0] idx, input logic [31:0] val);
    @(negedge clk); bd_we = 1; bd_idx = idx; bd_val = val;
    @(negedge clk); bd_we = 0;
  endtask

  // bench copy of configuration
  logic [19:0] base_pg = '0;
  logic        en_b = 0;
  task automatic set_base(input logic [31:0] v);
    @(negedge clk); cfg_base_we = 1; cfg_base_wdata = v;
    @(negedge clk); cfg_base_we = 0; base_pg = v[31:12];
  endtask
  task automatic set_en(input logic v);
    @(negedge clk); cfg_en_we = 1; cfg_en_wdata = v;
    @(negedge clk); cfg_en_we = 0; en_b = v;
  endtask

  typedef struct { logic flt; logic [2:0] err; logic [31:0] phys; logic [31:0] lin; } exp_t;
  exp_t sb[$];
  string cur_tag = "";

  // monitor
  always @(negedge clk) begin
    if (rst_n && (rsp_done || rsp_fault)) begin
      if (sb.size() == 0) chk(0, {cur_tag, " R11 unexpected result pulse"}, 32'(rsp_done), 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_fault == e.flt, {cur_tag, " R11 result kind (fault)"}, 32'(rsp_fault), 32'(e.flt));
        if (e.flt) begin
          chk(rsp_err == e.err, {cur_tag, " R4/R7 error code"}, 32'(rsp_err), 32'(e.err));
          chk(fault_addr == e.lin, {cur_tag, " R10 fault address"}, fault_addr, e.lin);
        end else
          chk(rsp_phys == e.phys, {cur_tag, " R3 physical address"}, rsp_phys, e.phys);
      end
    end
  end

  // reference walk from the requirements
  exp_t        r_e;
  int          r_nw, r_na;
  bit          r_cd, r_ct;
  logic [11:0] r_di, r_ti;
  logic [31:0] r_dv, r_tv;
  task automatic ref_walk(input logic [31:0] lin, input logic wr, input logic usr);
    logic [31:0] da, ta, pde, pte;
    bit udeny, wdeny;
    r_e.lin = lin; r_e.flt = 0; r_e.err = 0; r_e.phys = lin;
    r_nw = 0; r_na = 0; r_cd = 0; r_ct = 0;
    if (!en_b) return;
    da = {base_pg, lin[31:22], 2'b00};
    r_di = da[13:2]; pde = mem[r_di]; r_na = 1;
    if (!pde[0]) begin r_e.flt = 1; r_e.err = {usr, wr, 1'b0}; return; end
    r_cd = 1; r_dv = pde | 32'h20;
    if (!pde[5]) begin r_nw++; r_na++; end
    ta = {pde[31:12], lin[21:12], 2'b00};
    r_ti = ta[13:2]; pte = mem[r_ti]; r_na++;
    if (!pte[0]) begin r_e.flt = 1; r_e.err = {usr, wr, 1'b0}; return; end
    udeny = strict_user ? (!pde[2] || !pte[2]) : (!pde[2] && !pte[2]);
    wdeny = wr && (!pde[1] || !pte[1]);
    r_ct = 1; r_tv = pte;
    if (usr && (udeny || wdeny)) begin r_e.flt = 1; r_e.err = 3'b101 | {1'b0, wr, 1'b0}; return; end
    r_tv = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (r_tv != pte) begin r_nw++; r_na++; end
    r_e.phys = {pte[31:12], lin[11:0]};
  endtask

  // driver
  task automatic run(input string tag, input logic [31:0] lin, input logic wr, input logic usr);
    int w0, a0;
    cur_tag = tag;
    ref_walk(lin, wr, usr);
    sb.push_back(r_e);
    w0 = n_wr; a0 = n_acc;
    @(negedge clk);
    req_valid = 1; req_lin = lin; req_write = wr; req_user = usr;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready, {tag, " R11 busy after accept"}, {30'd0, busy, req_ready}, 32'd2);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(n_wr - w0 == r_nw, {tag, " R8/R9 write-back count"}, 32'(n_wr - w0), 32'(r_nw));
    chk(n_acc - a0 == r_na, {tag, " R2/R3 memory access count"}, 32'(n_acc - a0), 32'(r_na));
    if (r_cd) chk(mem[r_di] == r_dv, {tag, " R8 directory entry"}, mem[r_di], r_dv);
    if (r_ct) chk(mem[r_ti] == r_tv, {tag, " R9 table entry"}, mem[r_ti], r_tv);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && !rsp_done && !rsp_fault && !mem_req,
        "R1 idle after reset", {27'd0, req_ready, busy, rsp_done, rsp_fault, mem_req}, 32'h10);
    chk(fault_addr == 0, "R1 fault address reset", fault_addr, 0);

    // tables: dir@0x0000, tables @0x1000/0x2000, alternate dir @0x3000
    poke(12'h001, 32'h0000_1007);
    poke(12'h405, 32'h0ABC_D007);
    poke(12'h408, 32'h0007_7005);
    poke(12'h002, 32'h0000_2003);
    poke(12'h800, 32'h0005_5007);
    poke(12'h801, 32'h0006_6003);
    poke(12'hC01, 32'h0000_1027);

    run("R2 paging off", 32'h1234_5678, 0, 0);
    set_en(1);
    run("R3 R8 R9 first read", 32'h0040_5123, 0, 0);
    run("R8 R9 repeat read", 32'h0040_5123, 0, 0);
    run("R9 supervisor write sets dirty", 32'h0040_5ABC, 1, 0);
    run("R4 R10 dir not present user write", 32'h01C0_0010, 1, 1);
    run("R4 table not present read", 32'h0040_6000, 0, 0);
    strict_user = 0;
    run("R5 relaxed one level user", 32'h0080_0010, 0, 1);
    strict_user = 1;
    run("R5 R7 strict one level user", 32'h0080_0010, 0, 1);
    run("R5 strict both clear", 32'h0080_1000, 0, 1);
    strict_user = 0;
    run("R5 relaxed both clear", 32'h0080_1000, 0, 1);
    run("R6 R7 user write read-only", 32'h0040_8004, 1, 1);
    run("R6 user read read-only", 32'h0040_8008, 0, 1);
    run("R6 supervisor write read-only", 32'h0040_8004, 1, 0);
    set_base(32'h0000_3ABC);
    run("R3 base reload", 32'h0040_5123, 0, 0);
    chk(fault_addr == 32'h0040_8004, "R10 fault address held", fault_addr, 32'h0040_8004);
    set_en(0);
    run("R2 paging off again", 32'h0040_5FFF, 1, 1);
    chk(bad_addr == 0, "R3 addresses inside table area", 32'(bad_addr), 0);
    finish_run();
  end
endmodule